// File: doc/BRIEF.md
# Multi-Edge PWM Channel

This block is a single pulse-width-modulation channel. A free-running counter counts clock ticks through a programmable period. Inside each period the output starts at a programmable resting level and can flip up to three times. The flip points are given as three segment lengths: the first flip comes after the first segment, the second after the first two segments together, and the third after all three. A segment of length zero simply drops its flip.

New settings arrive through a one-cycle update strobe. They are checked first: the three segments together must be shorter than the period. A rejected request raises an error flag and leaves the running settings alone. An accepted request is held in a shadow copy. While the channel is running, that copy moves into the working registers only at the next period boundary, so a period is never cut short or reshaped halfway through. While the channel is idle, the copy is applied at once.

The channel has start and stop controls. It also gives a one-cycle pulse on the last tick of every period.

Top module: `tri_edge_pwm`

## Requirements
- R1: After reset the channel is idle, `pwm_o` is low (the default resting level is 0), and `period_end_o` and `cfg_err_o` are low.
- R2: While running, the internal count goes 0, 1, …, P−1 and then back to 0, where P is the working period. `period_end_o` is high exactly in the cycle whose count is P−1, so it pulses once every P cycles (every cycle when P is 1).
- R3: While running with count c, `pwm_o` is the resting level XOR the parity of how many enabled flip points are at or below c. The flip points sit at s1, s1+s2 and s1+s2+s3.
- R4: A segment value of zero enables no flip, including when the first segment is zero. The other flip points keep their cumulative positions.
- R5: An update accepted while running changes neither the period, the flip points nor the resting level of the period in progress. The new values apply from the first cycle (count 0) of the next period.
- R6: An update accepted while idle is applied at the next clock edge. Its resting level appears on `pwm_o` in the following cycle, before any start.
- R7: An update is accepted only when s1+s2+s3 < P. The sum is formed without wrap-around. A rejected update changes no working setting and no queued setting.
- R8: `cfg_err_o` goes high in the cycle after a rejected update and low in the cycle after an accepted one. Otherwise it holds its value.
- R9: `stop_i` makes the channel idle at the next edge and clears the count. While idle, `pwm_o` equals the working resting level and `period_end_o` stays low. `stop_i` wins over a `start_i` in the same cycle.
- R10: `start_i` while idle begins running with count 0 in the next cycle. `start_i` while running has no effect on the count.
- R11: An update accepted in the cycle where `period_end_o` is high takes effect from count 0 of the very next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Requested period in ticks |
| seg1_i | input | CNT_W | Requested first segment length |
| seg2_i | input | CNT_W | Requested second segment length (0 = no second flip) |
| seg3_i | input | CNT_W | Requested third segment length (0 = no third flip) |
| init_lvl_i | input | 1 | Requested resting level at each period start |
| upd_i | input | 1 | One-cycle strobe that submits the requested settings |
| start_i | input | 1 | Begin counting from zero if idle |
| stop_i | input | 1 | Return to idle and clear the count |
| pwm_o | output | 1 | PWM waveform |
| period_end_o | output | 1 | High during the last tick of each period |
| cfg_err_o | output | 1 | Last submitted settings were rejected |

## Verification
The waveform is tried over two full periods for each of these settings:
- a single mid-period flip over a long period, which shows the count wrapping at a large value;
- three nonzero segments with both resting levels, which shows the cumulative flip positions and the polarity;
- a zero in the first segment, and a zero in a middle segment, which shows that a dropped flip does not shift the later ones;
- segments that add up to exactly one less than the period, which is the widest legal setting;
- a period of one, and no flips at all.

Directed sequences then submit updates in several situations: partway through a period, on the boundary cycle itself, while idle, and with sums that equal the period or that would wrap in the field width. Each of these separates "applied at once" from "applied at the next boundary" from "rejected". A stop issued together with a start, and a start issued while running, show the control priority.

// File: rtl/tep_pkg.sv
`timescale 1ns/1ps
package tep_pkg;

   // Number of duty segments (and therefore maximum flips per period).
   localparam int unsigned NUM_SEG = 3;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } run_state_e;

endpackage

// File: rtl/tep_cfg_guard.sv
`timescale 1ns/1ps
// Checks submitted settings against the period rule, keeps the shadow copy
// and the error flag, and presents the values to load on the next commit.
module tep_cfg_guard
   import tep_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             upd_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] seg_i [NUM_SEG],
   input  logic             init_i,
   input  logic             commit_i,
   output logic             ld_avail_o,
   output logic [CNT_W-1:0] ld_period_o,
   output logic [CNT_W-1:0] ld_seg_o [NUM_SEG],
   output logic             ld_init_o,
   output logic             err_o
);

   localparam int unsigned SUM_W = CNT_W + $clog2(NUM_SEG + 1);

   logic [SUM_W-1:0] total;
   logic             fits;
   logic             accept;
   logic             reject;

   logic [CNT_W-1:0] sh_period_q;
   logic [CNT_W-1:0] sh_seg_q [NUM_SEG];
   logic             sh_init_q;
   logic             pend_q;
   logic             err_q;

   // Sum is widened so that large segment values cannot wrap into range.
   always_comb begin
      total = '0;
      for (int k = 0; k < NUM_SEG; k++) begin
         total = total + SUM_W'(seg_i[k]);
      end
   end

   assign fits   = total < SUM_W'(period_i);
   assign accept = upd_i & fits;
   assign reject = upd_i & ~fits;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_period_q <= '0;
         sh_init_q   <= 1'b0;
         for (int k = 0; k < NUM_SEG; k++) begin
            sh_seg_q[k] <= '0;
         end
      end else if (accept) begin
         sh_period_q <= period_i;
         sh_init_q   <= init_i;
         for (int k = 0; k < NUM_SEG; k++) begin
            sh_seg_q[k] <= seg_i[k];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= 1'b0;
      end else if (commit_i) begin
         pend_q <= 1'b0;
      end else if (accept) begin
         pend_q <= 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         err_q <= 1'b0;
      end else if (reject) begin
         err_q <= 1'b1;
      end else if (accept) begin
         err_q <= 1'b0;
      end
   end

   // A request arriving on the commit cycle bypasses the shadow copy.
   always_comb begin
      if (accept) begin
         ld_period_o = period_i;
         ld_init_o   = init_i;
         for (int k = 0; k < NUM_SEG; k++) begin
            ld_seg_o[k] = seg_i[k];
         end
      end else begin
         ld_period_o = sh_period_q;
         ld_init_o   = sh_init_q;
         for (int k = 0; k < NUM_SEG; k++) begin
            ld_seg_o[k] = sh_seg_q[k];
         end
      end
   end

   assign ld_avail_o = accept | pend_q;
   assign err_o      = err_q;

endmodule

// File: rtl/tep_active_bank.sv
`timescale 1ns/1ps
// Working settings. REG_EDGES selects whether cumulative flip positions are
// computed once at load time (stored) or on every cycle from stored segments.
module tep_active_bank
   import tep_pkg::*;
#(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned DEF_PERIOD = 16,
   parameter bit          DEF_INIT   = 1'b0,
   parameter bit          REG_EDGES  = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] seg_i [NUM_SEG],
   input  logic             init_i,
   output logic [CNT_W-1:0] period_o,
   output logic [CNT_W-1:0] edge_o [NUM_SEG],
   output logic [NUM_SEG-1:0] en_o,
   output logic             init_o
);

   logic [CNT_W-1:0] period_q;
   logic             init_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         period_q <= CNT_W'(DEF_PERIOD);
         init_q   <= DEF_INIT;
      end else if (load_i) begin
         period_q <= period_i;
         init_q   <= init_i;
      end
   end

   assign period_o = period_q;
   assign init_o   = init_q;

   if (REG_EDGES) begin : g_stored_edges
      logic [CNT_W-1:0]   cum     [NUM_SEG];
      logic [CNT_W-1:0]   edge_q  [NUM_SEG];
      logic [NUM_SEG-1:0] en_q;

      always_comb begin
         logic [CNT_W-1:0] acc;
         acc = '0;
         for (int k = 0; k < NUM_SEG; k++) begin
            acc    = acc + seg_i[k];
            cum[k] = acc;
         end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            en_q <= '0;
            for (int k = 0; k < NUM_SEG; k++) begin
               edge_q[k] <= '0;
            end
         end else if (load_i) begin
            for (int k = 0; k < NUM_SEG; k++) begin
               edge_q[k] <= cum[k];
               en_q[k]   <= (seg_i[k] != '0);
            end
         end
      end

      assign edge_o = edge_q;
      assign en_o   = en_q;
   end else begin : g_live_edges
      logic [CNT_W-1:0] seg_q [NUM_SEG];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int k = 0; k < NUM_SEG; k++) begin
               seg_q[k] <= '0;
            end
         end else if (load_i) begin
            for (int k = 0; k < NUM_SEG; k++) begin
               seg_q[k] <= seg_i[k];
            end
         end
      end

      always_comb begin
         logic [CNT_W-1:0] acc;
         acc = '0;
         for (int k = 0; k < NUM_SEG; k++) begin
            acc       = acc + seg_q[k];
            edge_o[k] = acc;
            en_o[k]   = (seg_q[k] != '0);
         end
      end
   end

endmodule

// File: rtl/tep_period_ctr.sv
`timescale 1ns/1ps
// Run/idle control and the wrapping tick counter.
module tep_period_ctr
   import tep_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             run_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             end_o
);

   run_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last_tick;

   assign last_tick = (st_q == ST_RUN) && (cnt_q == period_i - 1'b1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else if (stop_i) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else if (st_q == ST_IDLE) begin
         cnt_q <= '0;
         if (start_i) begin
            st_q <= ST_RUN;
         end
      end else if (last_tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign run_o = (st_q == ST_RUN);
   assign cnt_o = cnt_q;
   assign end_o = last_tick;

endmodule

// File: rtl/tep_edge_stage.sv
`timescale 1ns/1ps
// Compares the count with each flip point and forms the output level.
module tep_edge_stage
   import tep_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic               run_i,
   input  logic [CNT_W-1:0]   cnt_i,
   input  logic [CNT_W-1:0]   edge_i [NUM_SEG],
   input  logic [NUM_SEG-1:0] en_i,
   input  logic               init_i,
   output logic               pwm_o
);

   logic [NUM_SEG-1:0] passed;

   for (genvar k = 0; k < NUM_SEG; k++) begin : g_cmp
      assign passed[k] = en_i[k] && (cnt_i >= edge_i[k]);
   end

   assign pwm_o = init_i ^ (run_i & (^passed));

endmodule

// File: rtl/tri_edge_pwm.sv
`timescale 1ns/1ps
module tri_edge_pwm
   import tep_pkg::*;
#(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned DEF_PERIOD = 16,
   parameter bit          DEF_INIT   = 1'b0,
   parameter bit          REG_EDGES  = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] seg1_i,
   input  logic [CNT_W-1:0] seg2_i,
   input  logic [CNT_W-1:0] seg3_i,
   input  logic             init_lvl_i,
   input  logic             upd_i,
   input  logic             start_i,
   input  logic             stop_i,
   output logic             pwm_o,
   output logic             period_end_o,
   output logic             cfg_err_o
);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("tri_edge_pwm: CNT_W must lie in 2..32");
   end
   if (DEF_PERIOD < 1 || 64'(DEF_PERIOD) >= (64'd1 << CNT_W)) begin : g_bad_period
      $error("tri_edge_pwm: DEF_PERIOD must be at least 1 and fit CNT_W");
   end

   logic [CNT_W-1:0]   seg_req  [NUM_SEG];
   logic [CNT_W-1:0]   ld_seg   [NUM_SEG];
   logic [CNT_W-1:0]   ld_period;
   logic               ld_init;
   logic               ld_avail;
   logic               commit;

   logic [CNT_W-1:0]   act_period;
   logic [CNT_W-1:0]   act_edge [NUM_SEG];
   logic [NUM_SEG-1:0] act_en;
   logic               act_init;

   logic               running;
   logic [CNT_W-1:0]   cnt;
   logic               last_tick;

   assign seg_req[0] = seg1_i;
   assign seg_req[1] = seg2_i;
   assign seg_req[2] = seg3_i;

   // Settings move into the working bank while idle or on the last tick.
   assign commit = ~running | last_tick;

   tep_cfg_guard #(
      .CNT_W (CNT_W)
   ) guard_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .upd_i       (upd_i),
      .period_i    (period_i),
      .seg_i       (seg_req),
      .init_i      (init_lvl_i),
      .commit_i    (commit),
      .ld_avail_o  (ld_avail),
      .ld_period_o (ld_period),
      .ld_seg_o    (ld_seg),
      .ld_init_o   (ld_init),
      .err_o       (cfg_err_o)
   );

   tep_active_bank #(
      .CNT_W      (CNT_W),
      .DEF_PERIOD (DEF_PERIOD),
      .DEF_INIT   (DEF_INIT),
      .REG_EDGES  (REG_EDGES)
   ) bank_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (commit & ld_avail),
      .period_i (ld_period),
      .seg_i    (ld_seg),
      .init_i   (ld_init),
      .period_o (act_period),
      .edge_o   (act_edge),
      .en_o     (act_en),
      .init_o   (act_init)
   );

   tep_period_ctr #(
      .CNT_W (CNT_W)
   ) ctr_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start_i),
      .stop_i   (stop_i),
      .period_i (act_period),
      .run_o    (running),
      .cnt_o    (cnt),
      .end_o    (last_tick)
   );

   tep_edge_stage #(
      .CNT_W (CNT_W)
   ) edges_i (
      .run_i  (running),
      .cnt_i  (cnt),
      .edge_i (act_edge),
      .en_i   (act_en),
      .init_i (act_init),
      .pwm_o  (pwm_o)
   );

   assign period_end_o = last_tick;

endmodule

// File: rtl/tri_edge_pwm_chk.sv
`timescale 1ns/1ps
module tri_edge_pwm_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             upd_i,
   input logic             start_i,
   input logic             stop_i,
   input logic [CNT_W-1:0] period_i,
   input logic [CNT_W-1:0] seg1_i,
   input logic [CNT_W-1:0] seg2_i,
   input logic [CNT_W-1:0] seg3_i,
   input logic             pwm_o,
   input logic             period_end_o,
   input logic             cfg_err_o,
   input logic             running,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] act_period,
   input logic             act_init
);

   logic [CNT_W+1:0] req_sum;
   logic             req_ok;

   assign req_sum = {2'b00, seg1_i} + {2'b00, seg2_i} + {2'b00, seg3_i};
   assign req_ok  = req_sum < {2'b00, period_i};

   p_cnt_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      running |-> (cnt < act_period));

   p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running && period_end_o && !stop_i) |=> (running && cnt == '0));

   p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running && !period_end_o && !stop_i) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   p_hold_cfg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running && !period_end_o && !stop_i) |=> ($stable(act_period) && $stable(act_init)));

   p_reject_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i && !req_ok) |=> cfg_err_o);

   p_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_i && req_ok) |=> !cfg_err_o);

   p_err_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !upd_i |=> $stable(cfg_err_o));

   p_idle_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !running |-> (pwm_o == act_init && !period_end_o));

   p_stop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> (!running && cnt == '0));

   p_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!running && start_i && !stop_i) |=> (running && cnt == '0));

endmodule

bind tri_edge_pwm tri_edge_pwm_chk #(
   .CNT_W (CNT_W)
) chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .upd_i        (upd_i),
   .start_i      (start_i),
   .stop_i       (stop_i),
   .period_i     (period_i),
   .seg1_i       (seg1_i),
   .seg2_i       (seg2_i),
   .seg3_i       (seg3_i),
   .pwm_o        (pwm_o),
   .period_end_o (period_end_o),
   .cfg_err_o    (cfg_err_o),
   .running      (running),
   .cnt          (cnt),
   .act_period   (act_period),
   .act_init     (act_init)
);

// File: tb/tri_edge_pwm_tb_top.sv
`timescale 1ns/1ps
module tri_edge_pwm_tb_top;

   localparam int unsigned W = 16;

   // {period, seg1, seg2, seg3, init}
   localparam int NVEC = 8;
   localparam logic [64:0] VEC [NVEC] = '{
      {16'd200, 16'd100, 16'd0, 16'd0, 1'b0},
      {16'd12,  16'd3,   16'd4, 16'd2, 1'b0},
      {16'd12,  16'd3,   16'd4, 16'd2, 1'b1},
      {16'd10,  16'd0,   16'd5, 16'd0, 1'b1},
      {16'd8,   16'd2,   16'd0, 16'd3, 1'b0},
      {16'd5,   16'd1,   16'd1, 16'd2, 1'b0},
      {16'd1,   16'd0,   16'd0, 16'd0, 1'b1},
      {16'd20,  16'd0,   16'd0, 16'd0, 1'b0}
   };

   logic         clk;
   logic         rst_n;
   logic [W-1:0] period, s1, s2, s3;
   logic         init_lvl, upd, start, stop;
   logic         pwm, pend, err;

   int n_chk = 0;
   int n_bad = 0;

   tri_edge_pwm #(.CNT_W(W)) dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .period_i     (period),
      .seg1_i       (s1),
      .seg2_i       (s2),
      .seg3_i       (s3),
      .init_lvl_i   (init_lvl),
      .upd_i        (upd),
      .start_i      (start),
      .stop_i       (stop),
      .pwm_o        (pwm),
      .period_end_o (pend),
      .cfg_err_o    (err)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Expected level from the requirements: resting level XOR parity of
   // enabled cumulative flip points already reached.
   function automatic int lvl(int c, int p_s1, int p_s2, int p_s3, int ini);
      int n = 0;
      if (p_s1 != 0 && c >= p_s1) n++;
      if (p_s2 != 0 && c >= p_s1 + p_s2) n++;
      if (p_s3 != 0 && c >= p_s1 + p_s2 + p_s3) n++;
      return ini ^ (n % 2);
   endfunction

   task automatic set_cfg(input int p, input int a, input int b, input int c, input int ini);
      period   = W'(p);
      s1       = W'(a);
      s2       = W'(b);
      s3       = W'(c);
      init_lvl = ini[0];
      upd      = 1'b1;
      @(negedge clk);
      upd      = 1'b0;
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_chk(input int p, input int a, input int b, input int c, input int ini,
                          input int c0, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         int cc;
         cc = (c0 + i) % p;
         chk({tag, " level"}, int'(pwm), lvl(cc, a, b, c, ini));
         chk({"R2 boundary"}, int'(pend), (cc == p - 1) ? 1 : 0);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; period = '0; s1 = '0; s2 = '0; s3 = '0;
      init_lvl = 1'b0; upd = 1'b0; start = 1'b0; stop = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 pwm", int'(pwm), 0);
      chk("R1 period_end", int'(pend), 0);
      chk("R1 err", int'(err), 0);
      repeat (20) @(negedge clk);
      chk("R1 idle no boundary", int'(pend), 0);

      // Vector table: apply while idle, start, observe two periods, stop.
      for (int v = 0; v < NVEC; v++) begin
         int p, a, b, c, ini;
         string tag;
         p   = int'(VEC[v][64:49]);
         a   = int'(VEC[v][48:33]);
         b   = int'(VEC[v][32:17]);
         c   = int'(VEC[v][16:1]);
         ini = int'(VEC[v][0]);
         tag = (a == 0 || b == 0 || c == 0) ? "R4" : "R3";
         set_cfg(p, a, b, c, ini);
         pulse_start();                          // R10: count 0 here
         run_chk(p, a, b, c, ini, 0, 2 * p, tag);
         stop = 1'b1;
         @(negedge clk);
         stop = 1'b0;
         chk("R9 stop level", int'(pwm), ini);
         chk("R9 stop boundary", int'(pend), 0);
      end

      // R6: idle update visible at once
      set_cfg(10, 4, 0, 0, 1);
      chk("R6 idle init high", int'(pwm), 1);
      set_cfg(10, 4, 0, 0, 0);
      chk("R6 idle init low", int'(pwm), 0);
      chk("R8 accepted", int'(err), 0);

      // R7/R8: rejected requests
      set_cfg(10, 5, 5, 0, 1);                   // sum equals period
      chk("R8 reject flag", int'(err), 1);
      chk("R7 reject keeps level", int'(pwm), 0);
      set_cfg(10, 16'hFFFF, 16'hFFFF, 3, 1);     // would wrap to 1
      chk("R7 wrap reject flag", int'(err), 1);
      chk("R7 wrap reject level", int'(pwm), 0);
      pulse_start();
      run_chk(10, 4, 0, 0, 0, 0, 2, "R7");

      // R5: update partway through a period (count 2)
      chk("R5 pre-update level", int'(pwm), lvl(2, 4, 0, 0, 0));
      set_cfg(6, 1, 0, 0, 1);
      chk("R8 clear after accept", int'(err), 0);
      run_chk(10, 4, 0, 0, 0, 3, 7, "R5");
      run_chk(6, 1, 0, 0, 1, 0, 12, "R5");

      // R11: update on the boundary cycle
      run_chk(6, 1, 0, 0, 1, 0, 5, "R11");
      chk("R11 on boundary", int'(pend), 1);
      chk("R11 boundary level", int'(pwm), lvl(5, 1, 0, 0, 1));
      set_cfg(4, 1, 1, 1, 1);
      run_chk(4, 1, 1, 1, 1, 0, 8, "R11");

      // R10: start while running is ignored
      pulse_start();
      run_chk(4, 1, 1, 1, 1, 1, 7, "R10");

      // R9: stop together with start, stop wins
      run_chk(4, 1, 1, 1, 1, 0, 2, "R3");
      stop = 1'b1; start = 1'b1;
      @(negedge clk);
      stop = 1'b0; start = 1'b0;
      for (int i = 0; i < 5; i++) begin
         chk("R9 idle level", int'(pwm), 1);
         chk("R9 idle boundary", int'(pend), 0);
         @(negedge clk);
      end
      pulse_start();
      run_chk(4, 1, 1, 1, 1, 0, 4, "R10");

      // R7: rejected while running leaves waveform unchanged
      set_cfg(4, 2, 2, 0, 0);
      chk("R8 reject while running", int'(err), 1);
      run_chk(4, 1, 1, 1, 1, 1, 7, "R7");

      summary();
      $finish;
   end

endmodule